// File: doc/BRIEF.md
# Serially Configured Event Counter with Programmable Flag Output

This block counts events on a single input line and reports them through one configurable flag pin. Its whole behaviour is set by a 13-bit configuration word. The word is loaded bit by bit through a test-access style data-register path, which has separate capture, shift and update strobes. Shifting fills a staging register, and the live configuration changes only when the update strobe arrives. A capture strobe copies the live word back into the staging register so that it can be shifted out and read.

The event input is synchronised into the system clock. An edge qualifier then turns each transition into the active level into exactly one count pulse. An 8-bit counter steps up or down on each pulse. When it counts down, it can optionally freeze at zero. The flag pin shows one of four internal conditions: nothing, a combined error condition, the counter's end-of-range condition, or the event line itself. Polarity, error masking, enable and output style (open-drain or 3-state) are all programmable. The TAP controller is outside the block; its decoded states arrive as one-cycle strobes in the system clock domain.

Two small state machines carry the control flow. The edge qualifier has two states. EQ_BUSY waits for the event line to become inactive and moves to EQ_ARMED when it does. EQ_ARMED waits for the active level; on that level it emits one pulse and returns to EQ_BUSY. The counter also has two states. CS_COUNT applies pulses and moves to CS_HOLD when hold-at-zero is configured and the count is zero. CS_HOLD ignores pulses and returns to CS_COUNT once hold-at-zero is no longer configured. The configuration path decodes its strobes into the phases PH_IDLE, PH_CAPTURE, PH_SHIFT and PH_UPDATE.

Top module: `scan_event_counter`

## Requirements
- R1: The staging register is 13 bits wide. While `shift_dr` is high, each clock shifts it one place toward bit 0, with `tdi` entering bit 12, and `tdo` always shows staging bit 0. `cap_dr` copies the live configuration into the staging register. The live configuration changes only on a cycle with `upd_dr` high, and then takes the staging value.
- R2: Reset clears the live configuration, the staging register and the counter to 0. After reset `flag_oe` is 0, `flag_out` is 1 and `tdo` is 0.
- R3: Configuration bit 12 sets the count direction: 0 counts up and 1 counts down.
- R4: When bits 12 and 11 are both 1 and the count is 0, the counter holds at 0 and ignores events. With bit 12 at 0, bit 11 has no effect.
- R5: Without hold-at-zero, the count wraps modulo 256 in both directions.
- R6: Bits 9:8 select the flag source: 00 is never asserted, 01 is the error condition, 10 is end-of-range, and 11 is the event line at its active level.
- R7: End-of-range is asserted when the count is 0 while counting down, or 255 while counting up.
- R8: Bit 10 sets the flag polarity: 0 drives an asserted source as 0, and 1 drives it as 1. Bit 4 sets the event-line polarity: 0 means active-low and 1 means active-high.
- R9: The error condition is `err_a` OR `err_b` (both active-high). When bit 7 is 1, the error condition is forced off.
- R10: `flag_oe` is 0 whenever bit 5 is 0. With bit 5 at 1, bit 6 = 1 (3-state) makes `flag_oe` 1. Bit 6 = 0 (open-drain) makes `flag_oe` 1 only while `flag_out` is 0.
- R11: Each transition of `dci` into its active level produces exactly one count, however long that level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_dr | input | 1 | Capture strobe: copy live configuration to staging |
| shift_dr | input | 1 | Shift strobe: move staging one bit toward `tdo` |
| upd_dr | input | 1 | Update strobe: load live configuration from staging |
| tdi | input | 1 | Serial data into staging bit 12 |
| tdo | output | 1 | Staging bit 0 |
| dci | input | 1 | Event input, asynchronous |
| err_a | input | 1 | Error condition A, active-high |
| err_b | input | 1 | Error condition B, active-high |
| flag_out | output | 1 | Flag pin level |
| flag_oe | output | 1 | Flag pin drive enable |

## Verification
The bench builds the block with its default values: an 8-bit counter, a 13-bit configuration word and a two-stage synchroniser. With an 8-bit counter, both end-of-range values and the wrap can be reached in a few hundred events. That makes it practical to test the boundary at 255 going up, the wrap back to 0, and the hold at 0 going down. The two-stage synchroniser keeps the event-to-count delay at three cycles, so the event pulses stay short.

// File: rtl/sec_pkg.sv
package sec_pkg;

    localparam int CFG_W = 13;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'b00,
        SRC_ERR  = 2'b01,
        SRC_END  = 2'b10,
        SRC_EVT  = 2'b11
    } sec_src_e;

    // field order follows the serial bit positions, MSB first
    typedef struct packed {
        logic       down;       // bit 12
        logic       hold_zero;  // bit 11
        logic       flag_hi;    // bit 10
        logic [1:0] src;        // bits 9:8
        logic       err_mask;   // bit 7
        logic       tristate;   // bit 6
        logic       flag_en;    // bit 5
        logic       evt_hi;     // bit 4
        logic [3:0] spare;      // bits 3:0
    } sec_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CAPTURE,
        PH_SHIFT,
        PH_UPDATE
    } sec_phase_e;

    typedef enum logic {
        EQ_BUSY,
        EQ_ARMED
    } sec_eq_e;

    typedef enum logic {
        CS_COUNT,
        CS_HOLD
    } sec_cs_e;

endpackage

// File: rtl/sec_cfg_reg.sv
module sec_cfg_reg
    import sec_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_dr,
    input  logic         shift_dr,
    input  logic         upd_dr,
    input  logic         tdi,
    output logic         tdo,
    output logic [W-1:0] live_cfg
);

    logic [W-1:0] stage_q;
    logic [W-1:0] live_q;
    sec_phase_e   phase;

    always_comb begin
        if (cap_dr)        phase = PH_CAPTURE;
        else if (shift_dr) phase = PH_SHIFT;
        else if (upd_dr)   phase = PH_UPDATE;
        else               phase = PH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            unique case (phase)
                PH_CAPTURE: stage_q <= live_q;
                PH_SHIFT:   stage_q <= {tdi, stage_q[W-1:1]};
                PH_UPDATE:  live_q  <= stage_q;
                PH_IDLE:    ;
            endcase
        end
    end

    assign tdo      = stage_q[0];
    assign live_cfg = live_q;

    AST_LIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_dr |=> $stable(live_q)); // R1

endmodule

// File: rtl/sec_edge_qual.sv
module sec_edge_qual
    import sec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dci,
    input  logic evt_hi,
    output logic evt_active,
    output logic evt_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    sec_eq_e                st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], dci};
    end

    assign evt_active = evt_hi ? sync_q[SYNC_STAGES-1] : !sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EQ_BUSY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d      = st_q;
        evt_pulse = 1'b0;
        unique case (st_q)
            EQ_BUSY:  if (!evt_active) st_d = EQ_ARMED;
            EQ_ARMED: if (evt_active) begin
                evt_pulse = 1'b1;
                st_d      = EQ_BUSY;
            end
        endcase
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse); // R11

endmodule

// File: rtl/sec_counter.sv
module sec_counter
    import sec_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_pulse,
    input  logic down,
    input  logic hold_zero,
    output logic end_hit
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    sec_cs_e          st_q, st_d;
    logic             hold_cfg;

    assign hold_cfg = down && hold_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CS_COUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CS_COUNT: begin
                if (evt_pulse) cnt_d = down ? cnt_q - 1'b1 : cnt_q + 1'b1;
                if (hold_cfg && cnt_d == '0) st_d = CS_HOLD;
            end
            CS_HOLD: if (!hold_cfg) st_d = CS_COUNT;
        endcase
    end

    assign end_hit = down ? (cnt_q == '0) : (cnt_q == TOP);

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_HOLD) |-> (cnt_q == '0)); // R4
    AST_NO_STRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_pulse |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/sec_flag_mux.sv
module sec_flag_mux
    import sec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sec_cfg_t cfg,
    input  logic     err_a,
    input  logic     err_b,
    input  logic     end_hit,
    input  logic     evt_active,
    output logic     flag_out,
    output logic     flag_oe
);

    logic     asserted;
    sec_src_e src;

    assign src = sec_src_e'(cfg.src);

    always_comb begin
        unique case (src)
            SRC_IDLE: asserted = 1'b0;
            SRC_ERR:  asserted = (err_a || err_b) && !cfg.err_mask;
            SRC_END:  asserted = end_hit;
            SRC_EVT:  asserted = evt_active;
        endcase
    end

    always_comb begin
        flag_out = cfg.flag_hi ? asserted : !asserted;
        if (!cfg.flag_en)      flag_oe = 1'b0;
        else if (cfg.tristate) flag_oe = 1'b1;
        else                   flag_oe = !flag_out;
    end

    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_oe && !cfg.tristate) |-> !flag_out); // R10
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_ERR && cfg.err_mask) |-> (flag_out == !cfg.flag_hi)); // R9

endmodule

// File: rtl/scan_event_counter.sv
module scan_event_counter
    import sec_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_dr,
    input  logic shift_dr,
    input  logic upd_dr,
    input  logic tdi,
    output logic tdo,
    input  logic dci,
    input  logic err_a,
    input  logic err_b,
    output logic flag_out,
    output logic flag_oe
);

    logic [CFG_W-1:0] live_bits;
    sec_cfg_t         cfg;
    logic             evt_active;
    logic             evt_pulse;
    logic             end_hit;

    assign cfg = sec_cfg_t'(live_bits);

    sec_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_dr   (cap_dr),
        .shift_dr (shift_dr),
        .upd_dr   (upd_dr),
        .tdi      (tdi),
        .tdo      (tdo),
        .live_cfg (live_bits)
    );

    sec_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_eq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dci        (dci),
        .evt_hi     (cfg.evt_hi),
        .evt_active (evt_active),
        .evt_pulse  (evt_pulse)
    );

    sec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .down      (cfg.down),
        .hold_zero (cfg.hold_zero),
        .end_hit   (end_hit)
    );

    sec_flag_mux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .err_a      (err_a),
        .err_b      (err_b),
        .end_hit    (end_hit),
        .evt_active (evt_active),
        .flag_out   (flag_out),
        .flag_oe    (flag_oe)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.flag_en |-> !flag_oe); // R10

endmodule

// File: tb/scan_event_counter_test.sv
module scan_event_counter_test;

    logic clk = 1'b0;
    logic rst_n, cap_dr, shift_dr, upd_dr, tdi, dci, err_a, err_b;
    logic tdo, flag_out, flag_oe;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #4 clk = ~clk;

    scan_event_counter uut (
        .clk(clk), .rst_n(rst_n), .cap_dr(cap_dr), .shift_dr(shift_dr),
        .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo), .dci(dci), .err_a(err_a),
        .err_b(err_b), .flag_out(flag_out), .flag_oe(flag_oe)
    );

    // {cfg[12:0], dci, err_a, err_b, exp_out, exp_oe}
    localparam logic [17:0] VEC [12] = '{
        {13'h0060, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 idle, low polarity
        {13'h0460, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R8 idle, high polarity
        {13'h0560, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R9 err_a
        {13'h0160, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R9 err_b, low polarity
        {13'h0560, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R9 no error
        {13'h05E0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R9 masked
        {13'h0660, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 up at 0 not end
        {13'h0770, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 event line active-high
        {13'h0760, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R8 event line active-low
        {13'h0020, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R10 open-drain released
        {13'h0420, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R10 open-drain driven low
        {13'h0440, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}   // R10 disabled
    };

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cap_dr = 0; shift_dr = 0; upd_dr = 0; tdi = 0;
        err_a = 0; err_b = 0;
        step(2);
        rst_n = 1'b1;
        step(4);
    endtask

    task automatic shift_in(logic [12:0] w);
        for (int i = 0; i < 13; i++) begin
            shift_dr = 1'b1; tdi = w[i];
            step();
        end
        shift_dr = 1'b0; tdi = 1'b0;
    endtask

    task automatic update();
        upd_dr = 1'b1; step(); upd_dr = 1'b0; step();
    endtask

    task automatic load(logic [12:0] w);
        shift_in(w);
        update();
    endtask

    task automatic event_pulse(logic hi, int len = 4);
        dci = hi; step(len);
        dci = !hi; step(4);
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [12:0] got;
        dci = 1'b0;
        do_reset();
        // R2 reset state
        chk("R2 oe", 16'(flag_oe), 16'h0);
        chk("R2 out", 16'(flag_out), 16'h1);
        chk("R2 tdo", 16'(tdo), 16'h0);

        // table walk over source, polarity, mask and output style
        do_reset();
        foreach (VEC[k]) begin
            dci = VEC[k][4]; err_a = VEC[k][3]; err_b = VEC[k][2];
            load(VEC[k][17:5]);
            step(4);
            chk($sformatf("R6/R8/R9/R10 vec%0d out", k), 16'(flag_out), 16'(VEC[k][1]));
            chk($sformatf("R6/R8/R9/R10 vec%0d oe", k), 16'(flag_oe), 16'(VEC[k][0]));
        end
        err_a = 0; err_b = 0;

        // R1 readback through capture
        do_reset();
        load(13'h1A5B);
        cap_dr = 1'b1; step(); cap_dr = 1'b0;
        for (int i = 0; i < 13; i++) begin
            got[i] = tdo;
            shift_dr = 1'b1; step();
        end
        shift_dr = 1'b0;
        chk("R1 readback", 16'(got), 16'h1A5B);

        // R1 no effect until update
        do_reset();
        load(13'h0060);
        chk("R1 before", 16'(flag_out), 16'h1);
        shift_in(13'h0460);
        chk("R1 shifted not live", 16'(flag_out), 16'h1);
        update();
        chk("R1 after update", 16'(flag_out), 16'h0);

        // R2 reset clears a loaded word
        do_reset();
        chk("R2 after reload", 16'(flag_oe), 16'h0);

        // R3 R5 R7 R11 counting up
        dci = 1'b0;
        do_reset();
        load(13'h0670);
        chk("R7 up at 0", 16'(flag_out), 16'h0);
        for (int i = 0; i < 254; i++) event_pulse(1'b1);
        chk("R3 up at 254", 16'(flag_out), 16'h0);
        event_pulse(1'b1, 40);
        chk("R11 long level one count", 16'(flag_out), 16'h1);
        event_pulse(1'b1);
        chk("R5 wrap up", 16'(flag_out), 16'h0);

        // R3 R5 counting down from 0
        do_reset();
        load(13'h1670);
        chk("R7 down at 0", 16'(flag_out), 16'h1);
        event_pulse(1'b1);
        chk("R5 wrap down", 16'(flag_out), 16'h0);

        // R4 hold at zero
        do_reset();
        load(13'h1E70);
        chk("R4 hold start", 16'(flag_out), 16'h1);
        repeat (3) event_pulse(1'b1);
        chk("R4 held", 16'(flag_out), 16'h1);
        load(13'h1670);
        chk("R4 released still 0", 16'(flag_out), 16'h1);
        event_pulse(1'b1);
        chk("R4 counts after release", 16'(flag_out), 16'h0);

        // R4 hold bit ignored counting up
        do_reset();
        load(13'h0E70);
        for (int i = 0; i < 255; i++) event_pulse(1'b1);
        chk("R4 up reaches 255", 16'(flag_out), 16'h1);
        event_pulse(1'b1);
        chk("R4 up wraps despite hold", 16'(flag_out), 16'h0);

        // R8 R11 active-low event line
        dci = 1'b1;
        do_reset();
        load(13'h1660);
        chk("R8 low-active start", 16'(flag_out), 16'h1);
        event_pulse(1'b0);
        chk("R8 low-active counted", 16'(flag_out), 16'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule